// File: doc/BRIEF.md
# Interlocked Byte Handshake Port

This block moves 8-bit bytes between a core and an external agent over a parallel bus and two handshake wires. One wire is an active-low "byte available" strobe. The other is an active-low-going "acknowledge" line. A direction input picks which side sends. When the block receives, the agent owns the strobe and the port answers on the acknowledge line. When the block sends, the port owns the strobe and the agent answers on acknowledge. Each wire carries an output-enable, so the pad ring can turn the shared pins around.

Both directions use a full four-phase interlock. When receiving, the port captures the byte on the strobe's falling edge and pulls acknowledge low. Acknowledge stays low until the agent has released the strobe and the core has consumed the byte. When sending, the port first drives the byte and lowers the strobe one clock later. It raises the strobe once the agent acknowledges, and holds the bus until acknowledge is seen high again. Both incoming handshake lines pass through a synchronizer chain before any edge is detected.

Top module: `hsport`

## Requirements
- R1: After reset, `ack_o` and `avail_n_o` are 1, `rx_valid` and `pd_oe` are 0, and `tx_ready` is 1 once `dir_out` is 1 with `ack_i` high.
- R2: With `dir_out`=0 the port drives acknowledge (`ack_oe`=1, `avail_oe`=0). With `dir_out`=1 it drives the strobe (`avail_oe`=1, `ack_oe`=0).
- R3: In receive mode, a fall of `avail_n_i` causes the following on the third rising clock edge after the fall, and not before: the byte on `pd_i` appears on `rx_byte`, `rx_valid` becomes 1, and `ack_o` goes to 0. This timing comes from two synchronizer stages plus one state register.
- R4: In receive mode, `ack_o` stays 0 for as long as the synchronized strobe is low, even after the byte has been consumed.
- R5: In receive mode, while `rx_valid` is 1 and `rx_take` is 0, `rx_byte` holds its value and `ack_o` stays 0. `ack_o` returns to 1 on the clock edge at which the synchronized strobe is high and the byte is either already consumed or being taken by `rx_take` in that same cycle.
- R6: In send mode, `tx_req` while `tx_ready` is 1 captures `tx_byte`. On the next edge `pd_o` shows that byte and `pd_oe` is 1. `avail_n_o` falls exactly one clock later.
- R7: While `pd_oe` is 1, `pd_o` does not change. `pd_oe` drops on the third rising edge after `ack_i` returns high.
- R8: `avail_n_o` stays 0 until a fall of `ack_i` is detected, and returns to 1 on the third rising edge after that fall.
- R9: `tx_ready` is 0 from the capture of a byte until the transfer completes. A `tx_req` during that time is ignored and leaves `pd_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_out | input | 1 | 1 = port sends, 0 = port receives |
| pd_i | input | 8 | Parallel bus, pin input |
| pd_o | output | 8 | Parallel bus, pin output |
| pd_oe | output | 1 | Bus output enable |
| avail_n_i | input | 1 | Byte-available strobe, pin input (active low) |
| avail_n_o | output | 1 | Byte-available strobe, pin output (active low) |
| avail_oe | output | 1 | Strobe output enable |
| ack_i | input | 1 | Acknowledge, pin input |
| ack_o | output | 1 | Acknowledge, pin output |
| ack_oe | output | 1 | Acknowledge output enable |
| tx_byte | input | 8 | Byte to send |
| tx_req | input | 1 | Send request, accepted when tx_ready is 1 |
| tx_ready | output | 1 | Sender idle and able to accept a byte |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_byte holds an unconsumed byte |
| rx_take | input | 1 | Core consumes rx_byte |

## Verification
On the receive side, the core consuming the byte and the synchronized strobe release can land in the same cycle. The bench raises the strobe and counts two edges until the synchronizer output is high. It then asserts `rx_take` for exactly the cycle in which the release is evaluated. The check is that `ack_o` is still 0 one sample before that edge and is 1, with `rx_valid` cleared, one sample after it. The table walk also covers both orders in which these two events can arrive: take first, or release first.

// File: rtl/hsport_pkg.sv
package hsport_pkg;
   typedef enum logic [1:0] {
      TX_IDLE    = 2'd0,
      TX_SETUP   = 2'd1,
      TX_STROBE  = 2'd2,
      TX_RELEASE = 2'd3
   } tx_state_e;

   typedef enum logic {
      RX_IDLE = 1'b0,
      RX_HOLD = 1'b1
   } rx_state_e;
endpackage

// File: rtl/hsport_sync.sv
module hsport_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsport_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RESET_VAL;
      else        prev <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign fall_o  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/hsport_rx.sv
module hsport_rx
   import hsport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              avail_lvl,
   input  logic              avail_fall,
   input  logic [DATA_W-1:0] pd_i,
   input  logic              take,
   output logic              ack_o,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid
);
   rx_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
      end else if (!en) begin
         state    <= RX_IDLE;
         rx_valid <= 1'b0;
      end else begin
         if (take) rx_valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (avail_fall) begin
                  rx_byte  <= pd_i;
                  rx_valid <= 1'b1;
                  state    <= RX_HOLD;
               end
            end
            RX_HOLD: begin
               if (avail_lvl && (!rx_valid || take)) state <= RX_IDLE;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign ack_o = (state == RX_IDLE);

   AST_ACK_HELD_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (en && !ack_o && !avail_lvl) |=> (!ack_o || !en)); // R4
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) (en && rx_valid && !take) |=> ((rx_valid && $stable(rx_byte) && !ack_o) || !en)); // R5
endmodule

// File: rtl/hsport_tx.sv
module hsport_tx
   import hsport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ack_lvl,
   input  logic              ack_fall,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_req,
   output logic              tx_ready,
   output logic [DATA_W-1:0] pd_o,
   output logic              pd_oe,
   output logic              avail_n_o
);
   tx_state_e         state;
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         hold  <= '0;
      end else if (!en) begin
         state <= TX_IDLE;
      end else begin
         case (state)
            TX_IDLE: begin
               if (tx_req && ack_lvl) begin
                  hold  <= tx_byte;
                  state <= TX_SETUP;
               end
            end
            TX_SETUP:   state <= TX_STROBE;
            TX_STROBE:  if (ack_fall) state <= TX_RELEASE;
            TX_RELEASE: if (ack_lvl)  state <= TX_IDLE;
            default:    state <= TX_IDLE;
         endcase
      end
   end

   assign tx_ready  = en && (state == TX_IDLE) && ack_lvl;
   assign pd_oe     = en && (state != TX_IDLE);
   assign pd_o      = hold;
   assign avail_n_o = !(en && (state == TX_STROBE));

   AST_STROBE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n) $fell(avail_n_o) |-> $past(pd_oe)); // R6
   AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) pd_oe |=> (!pd_oe || $stable(pd_o))); // R7
   AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (en && !avail_n_o && ack_lvl) |=> (!avail_n_o || !en)); // R8
   AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> (!pd_oe && avail_n_o)); // R9
endmodule

// File: rtl/hsport.sv
module hsport #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_out,
   input  logic [DATA_W-1:0] pd_i,
   output logic [DATA_W-1:0] pd_o,
   output logic              pd_oe,
   input  logic              avail_n_i,
   output logic              avail_n_o,
   output logic              avail_oe,
   input  logic              ack_i,
   output logic              ack_o,
   output logic              ack_oe,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_req,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   input  logic              rx_take
);
   if (DATA_W < 1) begin : g_bad_width
      $error("hsport: DATA_W must be positive");
   end

   logic avail_lvl, avail_fall, ack_lvl, ack_fall;

   hsport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_avail_sync (
      .clk(clk), .rst_n(rst_n), .async_i(avail_n_i),
      .level_o(avail_lvl), .fall_o(avail_fall)
   );

   hsport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ack_i),
      .level_o(ack_lvl), .fall_o(ack_fall)
   );

   hsport_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(!dir_out),
      .avail_lvl(avail_lvl), .avail_fall(avail_fall), .pd_i(pd_i),
      .take(rx_take), .ack_o(ack_o), .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   hsport_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(dir_out),
      .ack_lvl(ack_lvl), .ack_fall(ack_fall), .tx_byte(tx_byte), .tx_req(tx_req),
      .tx_ready(tx_ready), .pd_o(pd_o), .pd_oe(pd_oe), .avail_n_o(avail_n_o)
   );

   assign avail_oe = dir_out;
   assign ack_oe   = !dir_out;

   AST_PIN_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({avail_oe, ack_oe}) && (avail_oe || ack_oe)); // R2
endmodule

// File: tb/hsport_test.sv
module hsport_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dir_out = 1'b0;
   logic [7:0] pd_i = 8'h00;
   logic [7:0] pd_o;
   logic       pd_oe;
   logic       avail_n_i = 1'b1;
   logic       avail_n_o, avail_oe;
   logic       ack_i = 1'b1;
   logic       ack_o, ack_oe;
   logic [7:0] tx_byte = 8'h00;
   logic       tx_req = 1'b0;
   logic       tx_ready;
   logic [7:0] rx_byte;
   logic       rx_valid;
   logic       rx_take = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   hsport uut (
      .clk(clk), .rst_n(rst_n), .dir_out(dir_out),
      .pd_i(pd_i), .pd_o(pd_o), .pd_oe(pd_oe),
      .avail_n_i(avail_n_i), .avail_n_o(avail_n_o), .avail_oe(avail_oe),
      .ack_i(ack_i), .ack_o(ack_o), .ack_oe(ack_oe),
      .tx_byte(tx_byte), .tx_req(tx_req), .tx_ready(tx_ready),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_take(rx_take)
   );

   // vector: {direction (1 = send), byte, variant}
   // receive variant 1: core takes before strobe release; 0: release first
   localparam logic [9:0] VEC [6] = '{
      {1'b0, 8'hA5, 1'b0},
      {1'b0, 8'h3C, 1'b1},
      {1'b1, 8'h5A, 1'b0},
      {1'b0, 8'hFF, 1'b1},
      {1'b1, 8'h00, 1'b0},
      {1'b1, 8'hC3, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_dir(input logic d);
      @(negedge clk);
      dir_out = d;
      step(3);
   endtask

   task automatic rx_xfer(input logic [7:0] b, input logic take_first);
      @(negedge clk);
      pd_i = b;
      avail_n_i = 1'b0;
      step(2);
      chk("R3 ack not yet low", ack_o, 1);
      step(1);
      chk("R3 ack low", ack_o, 0);
      chk("R3 byte", rx_byte, b);
      chk("R3 valid", rx_valid, 1);
      if (take_first) begin
         rx_take = 1'b1;
         step(1);
         rx_take = 1'b0;
         chk("R5 valid cleared", rx_valid, 0);
         step(4);
         chk("R4 ack low while strobe low", ack_o, 0);
         avail_n_i = 1'b1;
         pd_i = ~b;
         step(2);
         chk("R4 ack before sync", ack_o, 0);
         step(1);
         chk("R5 ack released", ack_o, 1);
      end else begin
         avail_n_i = 1'b1;
         pd_i = ~b;
         step(5);
         chk("R5 ack held until consumed", ack_o, 0);
         chk("R5 byte kept", rx_byte, b);
         rx_take = 1'b1;
         step(1);
         rx_take = 1'b0;
         chk("R5 ack released on take", ack_o, 1);
         chk("R5 valid cleared", rx_valid, 0);
      end
      step(2);
   endtask

   task automatic tx_xfer(input logic [7:0] b);
      @(negedge clk);
      chk("R9 ready before", tx_ready, 1);
      tx_byte = b;
      tx_req = 1'b1;
      step(1);
      tx_req = 1'b0;
      chk("R6 data driven", pd_o, b);
      chk("R6 oe", pd_oe, 1);
      chk("R6 strobe still high", avail_n_o, 1);
      chk("R9 ready low", tx_ready, 0);
      step(1);
      chk("R6 strobe low", avail_n_o, 0);
      step(3);
      chk("R8 strobe held", avail_n_o, 0);
      ack_i = 1'b0;
      step(2);
      chk("R8 strobe before sync", avail_n_o, 0);
      step(1);
      chk("R8 strobe released", avail_n_o, 1);
      chk("R7 oe kept", pd_oe, 1);
      tx_byte = ~b;
      tx_req = 1'b1;
      step(1);
      tx_req = 1'b0;
      chk("R9 request ignored", pd_o, b);
      ack_i = 1'b1;
      step(2);
      chk("R7 oe before sync", pd_oe, 1);
      chk("R7 data stable", pd_o, b);
      step(1);
      chk("R7 oe dropped", pd_oe, 0);
      chk("R9 ready again", tx_ready, 1);
      chk("R9 no second transfer", avail_n_o, 1);
      step(2);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 ack", ack_o, 1);
      chk("R1 strobe", avail_n_o, 1);
      chk("R1 valid", rx_valid, 0);
      chk("R1 oe", pd_oe, 0);
      chk("R2 rx ack_oe", ack_oe, 1);
      chk("R2 rx avail_oe", avail_oe, 0);
      set_dir(1'b1);
      chk("R1 ready", tx_ready, 1);
      chk("R1 strobe out mode", avail_n_o, 1);
      chk("R2 tx avail_oe", avail_oe, 1);
      chk("R2 tx ack_oe", ack_oe, 0);

      for (int i = 0; i < 6; i++) begin
         set_dir(VEC[i][9]);
         if (VEC[i][9]) tx_xfer(VEC[i][8:1]);
         else           rx_xfer(VEC[i][8:1], VEC[i][0]);
      end

      // R5: take and synchronized release in the same cycle
      set_dir(1'b0);
      @(negedge clk);
      pd_i = 8'h96;
      avail_n_i = 1'b0;
      step(4);
      chk("R3 byte same-cycle case", rx_byte, 8'h96);
      avail_n_i = 1'b1;
      step(2);
      rx_take = 1'b1;
      chk("R5 ack low before coincident edge", ack_o, 0);
      step(1);
      rx_take = 1'b0;
      chk("R5 coincident release", ack_o, 1);
      chk("R5 coincident valid", rx_valid, 0);

      // take with nothing pending has no effect
      rx_take = 1'b1;
      step(1);
      rx_take = 1'b0;
      chk("R5 idle take ack", ack_o, 1);
      chk("R5 idle take valid", rx_valid, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule